// File: doc/BRIEF.md
# ISDN 2B+D Serial Receive Demultiplexer

This block takes a time-division serial stream carrying two bearer channels and one signalling channel, all on one data pin. A one-cycle data-clock strobe, synchronous to the system clock, marks each incoming bit. A frame-sync input, sampled together with that strobe, marks the first bit of a frame.

Each bit is routed by its slot position to one of three independent packers. The two bearer packers each build a 32-bit word from four bytes. The signalling packer builds an 8-bit word from four 2-bit slots. A finished word is presented on a parallel output with a valid flag. A bus reader clears the flag with a one-cycle read strobe. If a word completes while the previous one is still unread, an overrun flag is raised.

If a frame sync arrives in the middle of a frame, the slot position is realigned at once. Slots that were already complete are kept. The slot that was cut short is thrown away.

Top module: `isdn_rx_demux`

## Requirements
- R1: After reset all data outputs are 0 and all valid and overrun flags are 0. Bits strobed before the first frame sync are ignored.
- R2: A bit is taken only in a cycle where `bit_en` is 1. When `fsync` is 1 in such a cycle, that bit is slot position 0. Positions 0-7 carry bearer 1, positions 8-15 carry bearer 2, and positions 16-17 carry signalling, each most significant bit first. Strobed bits after position 17 are ignored until the next frame sync.
- R3: Bearer 1 packs four bytes into `b1_data`, with the first byte received in bits [31:24]. The word and `b1_valid` appear right after the edge that samples the 32nd bit.
- R4: Bearer 2 packs into `b2_data` in the same way as R3, using its own slots and its own `b2_valid`.
- R5: Signalling packs four 2-bit slots into `d_data`, with the first slot in bits [7:6]. The word and `d_valid` appear right after the edge that samples the 8th bit.
- R6: A read strobe (`rd_b1`, `rd_b2`, `rd_d`) clears that channel's valid and overrun flags on the next edge and leaves the other channels alone. If a word completes in the same cycle as its read strobe, valid stays 1 and overrun stays 0.
- R7: If a word completes while its valid flag is still 1 and no read strobe is present, the overrun flag is set and the new word replaces the old one.
- R8: A frame sync in the middle of a frame restarts the position at bearer 1 bit 0. The unfinished slot of the channel that was cut short is discarded. Slots that were already complete stay in the word being built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | 1 | Data-clock strobe: sample `din` this cycle |
| fsync | input | 1 | Frame sync, qualified by `bit_en` |
| din | input | 1 | Serial data in |
| rd_b1 | input | 1 | Read strobe for bearer 1 |
| rd_b2 | input | 1 | Read strobe for bearer 2 |
| rd_d | input | 1 | Read strobe for signalling |
| b1_data | output | 32 | Bearer 1 packed word |
| b2_data | output | 32 | Bearer 2 packed word |
| d_data | output | 8 | Signalling packed word |
| b1_valid | output | 1 | Bearer 1 word ready |
| b2_valid | output | 1 | Bearer 2 word ready |
| d_valid | output | 1 | Signalling word ready |
| b1_ovr | output | 1 | Bearer 1 overrun |
| b2_ovr | output | 1 | Bearer 2 overrun |
| d_ovr | output | 1 | Signalling overrun |

## Verification
Each packed word and its valid flag take exactly one register stage. They change at the rising edge that samples the completing bit. A read strobe clears its flags at the edge that samples the strobe. The bench drives every bit and strobe on the falling edge and reads the outputs on the next falling edge. It also checks that no valid flag rises one frame early, and that a read strobe landing on the completing bit leaves valid set.

// File: rtl/isdn_rx_pkg.sv
package isdn_rx_pkg;
  localparam int B_SLOT_BITS = 8;
  localparam int D_SLOT_BITS = 2;
  localparam int B_WORD_BITS = 32;
  localparam int D_WORD_BITS = 8;
  localparam int FRAME_BITS  = 2 * B_SLOT_BITS + D_SLOT_BITS;
  localparam int POS_W       = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    CH_B1   = 2'd0,
    CH_B2   = 2'd1,
    CH_D    = 2'd2,
    CH_NONE = 2'd3
  } chan_e;
endpackage

// File: rtl/isdn_rx_framer.sv
module isdn_rx_framer
  import isdn_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_en,
  input  logic  fsync,
  output chan_e chan,
  output logic  resync
);
  localparam logic [POS_W-1:0] IDLE_POS = POS_W'(FRAME_BITS);
  localparam logic [POS_W-1:0] B2_POS   = POS_W'(B_SLOT_BITS);
  localparam logic [POS_W-1:0] D_POS    = POS_W'(2 * B_SLOT_BITS);

  logic [POS_W-1:0] pos_q, pos_n, pos_cur;

  always_comb begin
    pos_cur = fsync ? '0 : pos_q;
    resync  = bit_en & fsync;
    pos_n   = pos_q;
    chan    = CH_NONE;
    if (bit_en && pos_cur != IDLE_POS) begin
      pos_n = pos_cur + 1'b1;
      if (pos_cur < B2_POS)     chan = CH_B1;
      else if (pos_cur < D_POS) chan = CH_B2;
      else                      chan = CH_D;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= IDLE_POS;
    else        pos_q <= pos_n;
  end

  // R2: position never runs past the idle marker
  assert_pos_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= IDLE_POS);
  // R8: a qualified frame sync always lands the next bit at position 1
  assert_sync_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |=> pos_q == POS_W'(1));
  // R1: without a strobe the position holds
  assert_hold_without_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pos_q));
endmodule

// File: rtl/isdn_rx_packer.sv
module isdn_rx_packer #(
  parameter int WORD_BITS = 32,
  parameter int SLOT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_vld,
  input  logic                 bit_val,
  input  logic                 resync,
  input  logic                 rd,
  output logic [WORD_BITS-1:0] data,
  output logic                 valid,
  output logic                 ovr
);
  localparam int CW = $clog2(WORD_BITS);
  localparam logic [CW-1:0] LAST      = CW'(WORD_BITS - 1);
  localparam logic [CW-1:0] SLOT_MASK = ~CW'(SLOT_BITS - 1);

  logic [CW-1:0]        cnt_q, cnt_n, cnt_eff, idx;
  logic [WORD_BITS-1:0] asm_q, asm_n, data_n;
  logic                 valid_n, ovr_n, complete;

  always_comb begin
    cnt_eff  = resync ? (cnt_q & SLOT_MASK) : cnt_q;
    idx      = LAST - cnt_eff;
    asm_n    = asm_q;
    cnt_n    = cnt_eff;
    complete = 1'b0;
    if (bit_vld) begin
      asm_n[idx] = bit_val;
      complete   = (cnt_eff == LAST);
      cnt_n      = complete ? '0 : cnt_eff + 1'b1;
    end
    data_n  = complete ? asm_n : data;
    valid_n = valid;
    ovr_n   = ovr;
    if (rd) begin
      valid_n = 1'b0;
      ovr_n   = 1'b0;
    end
    if (complete) begin
      valid_n = 1'b1;
      if (valid && !rd) ovr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      asm_q <= '0;
      data  <= '0;
      valid <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      asm_q <= asm_n;
      data  <= data_n;
      valid <= valid_n;
      ovr   <= ovr_n;
    end
  end

  // R7: an overrun is only ever reported alongside a held word
  assert_ovr_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> valid);
  // R3: a word becomes ready only on a sampled channel bit
  assert_valid_rise_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(bit_vld));
  // R6: a read with no completion empties the flags
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !complete) |=> (!valid && !ovr));
  // R5: the word output changes only on a sampled channel bit
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(data));
endmodule

// File: rtl/isdn_rx_demux.sv
module isdn_rx_demux
  import isdn_rx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_en,
  input  logic                   fsync,
  input  logic                   din,
  input  logic                   rd_b1,
  input  logic                   rd_b2,
  input  logic                   rd_d,
  output logic [B_WORD_BITS-1:0] b1_data,
  output logic [B_WORD_BITS-1:0] b2_data,
  output logic [D_WORD_BITS-1:0] d_data,
  output logic                   b1_valid,
  output logic                   b2_valid,
  output logic                   d_valid,
  output logic                   b1_ovr,
  output logic                   b2_ovr,
  output logic                   d_ovr
);
  chan_e chan;
  logic  resync;
  logic  to_b1, to_b2, to_d;

  isdn_rx_framer u_framer (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .fsync  (fsync),
    .chan   (chan),
    .resync (resync)
  );

  assign to_b1 = (chan == CH_B1);
  assign to_b2 = (chan == CH_B2);
  assign to_d  = (chan == CH_D);

  isdn_rx_packer #(.WORD_BITS(B_WORD_BITS), .SLOT_BITS(B_SLOT_BITS)) u_b1 (
    .clk (clk), .rst_n (rst_n), .bit_vld (to_b1), .bit_val (din),
    .resync (resync), .rd (rd_b1),
    .data (b1_data), .valid (b1_valid), .ovr (b1_ovr)
  );

  isdn_rx_packer #(.WORD_BITS(B_WORD_BITS), .SLOT_BITS(B_SLOT_BITS)) u_b2 (
    .clk (clk), .rst_n (rst_n), .bit_vld (to_b2), .bit_val (din),
    .resync (resync), .rd (rd_b2),
    .data (b2_data), .valid (b2_valid), .ovr (b2_ovr)
  );

  isdn_rx_packer #(.WORD_BITS(D_WORD_BITS), .SLOT_BITS(D_SLOT_BITS)) u_d (
    .clk (clk), .rst_n (rst_n), .bit_vld (to_d), .bit_val (din),
    .resync (resync), .rd (rd_d),
    .data (d_data), .valid (d_valid), .ovr (d_ovr)
  );

  // R2: each sampled bit goes to at most one channel
  assert_one_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({to_b1, to_b2, to_d}));
  // R2: nothing is routed without a data-clock strobe
  assert_no_route_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> !(to_b1 || to_b2 || to_d));
endmodule

// File: tb/tb_isdn_rx_demux.sv
module tb_isdn_rx_demux;
  logic        clk, rst_n, bit_en, fsync, din, rd_b1, rd_b2, rd_d;
  logic [31:0] b1_data, b2_data;
  logic [7:0]  d_data;
  logic        b1_valid, b2_valid, d_valid, b1_ovr, b2_ovr, d_ovr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  isdn_rx_demux dut (.*);

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_bit_regs;
    bit_en = 0; fsync = 0; din = 0; rd_b1 = 0; rd_b2 = 0; rd_d = 0;
  endtask

  // one strobed bit driven at a falling edge
  task automatic put_bit(input logic v, input logic fs, input logic rdd);
    bit_en = 1; din = v; fsync = fs; rd_d = rdd;
    @(negedge clk);
    idle_bit_regs();
  endtask

  task automatic send_frame(input logic [7:0] b1, input logic [7:0] b2,
                            input logic [1:0] d, input int nbits, input bit rd_last);
    logic [17:0] fr;
    fr = {b1, b2, d};
    for (int i = 0; i < nbits; i++) begin
      put_bit(fr[17-i], i == 0, rd_last && i == 17);
      if (i % 5 == 2) @(negedge clk);
    end
    if (nbits == 18) for (int k = 0; k < 3; k++) put_bit(1'b1, 1'b0, 1'b0);
  endtask

  task automatic read_all;
    rd_b1 = 1; rd_b2 = 1; rd_d = 1;
    @(negedge clk);
    idle_bit_regs();
  endtask

  task automatic t_reset;
    chk("R1 b1_data", b1_data, 0);
    chk("R1 b2_data", b2_data, 0);
    chk("R1 d_data", {24'b0, d_data}, 0);
    chk("R1 flags", {26'b0, b1_valid, b2_valid, d_valid, b1_ovr, b2_ovr, d_ovr}, 0);
    for (int k = 0; k < 40; k++) put_bit(1'b1, 1'b0, 1'b0);
    chk("R1 no sync ignored", {29'b0, b1_valid, b2_valid, d_valid}, 0);
  endtask

  task automatic t_basic;
    send_frame(8'h11, 8'hA1, 2'b10, 18, 0);
    send_frame(8'h22, 8'hA2, 2'b01, 18, 0);
    send_frame(8'h33, 8'hA3, 2'b11, 18, 0);
    chk("R3 R4 R5 not early", {29'b0, b1_valid, b2_valid, d_valid}, 0);
    send_frame(8'h44, 8'hA4, 2'b00, 18, 0);
    chk("R3 b1 word", b1_data, 32'h11223344);
    chk("R4 b2 word", b2_data, 32'hA1A2A3A4);
    chk("R5 d word", {24'b0, d_data}, 32'h9C);
    chk("R2 valids set", {29'b0, b1_valid, b2_valid, d_valid}, 3'b111);
  endtask

  task automatic t_read;
    rd_b1 = 1;
    @(negedge clk);
    idle_bit_regs();
    chk("R6 b1 cleared others kept", {29'b0, b1_valid, b2_valid, d_valid}, 3'b011);
    rd_b2 = 1; rd_d = 1;
    @(negedge clk);
    idle_bit_regs();
    chk("R6 all cleared", {29'b0, b1_valid, b2_valid, d_valid}, 0);
  endtask

  task automatic t_overrun;
    for (int f = 0; f < 2; f++) begin
      send_frame(8'h01, 8'h05, 2'b01, 18, 0);
      send_frame(8'h02, 8'h06, 2'b10, 18, 0);
      send_frame(8'h03, 8'h07, 2'b11, 18, 0);
      send_frame(8'h04 + 8'(f), 8'h08, 2'b00, 18, 0);
    end
    chk("R7 ovr set", {29'b0, b1_ovr, b2_ovr, d_ovr}, 3'b111);
    chk("R7 b1 new data", b1_data, 32'h01020305);
    chk("R7 b2 new data", b2_data, 32'h05060708);
    read_all();
    chk("R6 ovr cleared", {26'b0, b1_valid, b2_valid, d_valid, b1_ovr, b2_ovr, d_ovr}, 0);
  endtask

  task automatic t_same_cycle;
    send_frame(8'h10, 8'h20, 2'b11, 18, 0);
    send_frame(8'h11, 8'h21, 2'b11, 18, 0);
    send_frame(8'h12, 8'h22, 2'b11, 18, 0);
    send_frame(8'h13, 8'h23, 2'b11, 18, 0);
    read_all();
    send_frame(8'h10, 8'h20, 2'b00, 18, 0);
    send_frame(8'h11, 8'h21, 2'b01, 18, 0);
    send_frame(8'h12, 8'h22, 2'b10, 18, 0);
    send_frame(8'h13, 8'h23, 2'b11, 18, 0);
    chk("R6 d valid before", {31'b0, d_valid}, 1);
    send_frame(8'h00, 8'h00, 2'b01, 18, 0);
    send_frame(8'h00, 8'h00, 2'b10, 18, 0);
    send_frame(8'h00, 8'h00, 2'b11, 18, 0);
    send_frame(8'h00, 8'h00, 2'b00, 18, 1);
    chk("R6 same-cycle valid kept, no ovr", {30'b0, d_valid, d_ovr}, 2'b10);
    chk("R5 d word second", {24'b0, d_data}, 32'h6C);
    read_all();
  endtask

  task automatic t_resync;
    send_frame(8'hC1, 8'hD1, 2'b01, 18, 0);
    send_frame(8'hC2, 8'hD2, 2'b10, 18, 0);
    send_frame(8'hC3, 8'hD3, 2'b11, 18, 0);
    send_frame(8'hC4, 8'hFF, 2'b11, 11, 0);
    chk("R8 b1 done with cut frame", b1_data, 32'hC1C2C3C4);
    chk("R8 b2 partial not done", {31'b0, b2_valid}, 0);
    send_frame(8'hE5, 8'hD4, 2'b00, 18, 0);
    chk("R8 b2 realigned", b2_data, 32'hD1D2D3D4);
    chk("R8 d realigned", {24'b0, d_data}, 32'h6C);
    read_all();
    send_frame(8'hE6, 8'h00, 2'b00, 18, 0);
    send_frame(8'hE7, 8'h00, 2'b00, 18, 0);
    send_frame(8'hFF, 8'h00, 2'b00, 4, 0);
    send_frame(8'hE8, 8'h00, 2'b00, 18, 0);
    chk("R8 b1 partial slot dropped", b1_data, 32'hE5E6E7E8);
  endtask

  initial begin
    idle_bit_regs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_read();
    t_overrun();
    t_same_cycle();
    t_resync();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule